// File: doc/BRIEF.md
# Flag-Generating 8-bit ALU

This block is the arithmetic and logic unit of a small accumulator-based processor. Each cycle it takes the accumulator, a second operand, a 3-bit operation code and the incoming carry flag. It produces the new accumulator value, a new flag byte and a writeback strobe, all registered one clock later. Eight two-operand operations are available: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. A separate step path increments or decrements the second operand on its own. The decoder uses that path for single-register counting.

The flag byte has the zero flag in bit 7, the subtract flag in bit 6, the half-carry flag in bit 5 and the carry flag in bit 4. Bits 3..0 are always zero. Half-carry follows nibble rules that differ between adds, subtracts, logic operations and steps. The step path never changes the carry flag. It copies the incoming carry through.

Top module: `alu8_flagged`

## Requirements
- R1: With `step_en`=0 and `op_sel`=000 (add), the result is (acc+opd) mod 256, subtract flag 0, half-carry 1 exactly when the two low nibbles sum above 0xF, carry 1 exactly when the full sum exceeds 0xFF.
- R2: `op_sel`=001 (add with carry) behaves as R1 with `carry_in` added into both the nibble sum and the full sum.
- R3: `op_sel`=010 (subtract) gives (acc-opd) mod 256, subtract flag 1, half-carry 1 when opd's low nibble is greater than acc's low nibble, carry 1 when opd is greater than acc.
- R4: `op_sel`=011 (subtract with borrow) gives (acc-opd-carry_in) mod 256, subtract flag 1, half-carry 1 when opd low nibble plus carry_in exceeds acc low nibble, carry 1 when opd plus carry_in exceeds acc.
- R5: `op_sel`=111 (compare) produces the same result value and flags as R3, with the writeback strobe 0.
- R6: `op_sel`=100 (AND) gives acc AND opd with half-carry 1 and subtract and carry flags 0.
- R7: `op_sel`=101 (XOR) and 110 (OR) give the bitwise result with subtract, half-carry and carry flags 0.
- R8: For every operation and step, flag bit 7 is 1 exactly when the 8-bit result is zero.
- R9: With `step_en`=1 and `step_down`=0, the result is opd+1 mod 256, subtract flag 0, half-carry 1 when the result's low nibble is 0, carry equal to `carry_in`; `op_sel` and `acc_in` have no effect.
- R10: With `step_en`=1 and `step_down`=1, the result is opd-1 mod 256, subtract flag 1, half-carry 1 when the result's low nibble is 0xF, carry equal to `carry_in`; `op_sel` and `acc_in` have no effect.
- R11: Flag bits 3..0 are always 0, and the writeback strobe is 1 for every operation and step except compare.
- R12: Outputs reflect the inputs of the previous rising clock edge. A synchronous active-low reset drives the result, flags and strobe to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 3 | Two-operand operation code |
| step_en | input | 1 | Selects the increment/decrement path |
| step_down | input | 1 | 1 = decrement, 0 = increment (step path only) |
| acc_in | input | 8 | Accumulator value |
| opd_in | input | 8 | Second operand, or the value being stepped |
| carry_in | input | 1 | Current carry flag |
| res_out | output | 8 | Registered result |
| flags_out | output | 8 | Registered flag byte {Z,N,H,C,0000} |
| wr_en_out | output | 1 | Registered accumulator/register writeback strobe |

## Verification
The hardest case to reach is subtract with borrow where the low nibbles are equal and only the incoming carry makes the borrow. For example 0x00-0x00 with carry set must give 0xFF with both half-carry and carry set. Uniform random operands reach that combination only about once in several hundred vectors. The stimulus therefore adds directed vectors with equal nibbles and carry set. Random vectors cover all eight operations with both carry values. The step path is swept over every operand with both directions and both carry values, so the wrap at 0xFF/0x00 and every nibble boundary are hit deliberately.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag bit positions for the ALU.
// Assumes an 8-bit flag byte with the flags in the upper nibble.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBC = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    localparam int FLAG_Z = 7;
    localparam int FLAG_N = 6;
    localparam int FLAG_H = 5;
    localparam int FLAG_C = 4;

endpackage

// File: rtl/alu8_addsub.sv
// Module: shared adder/subtractor with nibble and full-width carry-outs.
// Assumes DATA_W is even; the "half" flag is taken at DATA_W/2.
// For subtraction, half and carry are borrows (1 = borrow taken).
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              half_o,
    output logic              carry_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W:0] lo_ext;
    logic [DATA_W:0] full_ext;

    // Low-nibble partial: its top bit is the half carry or borrow.
    always_comb begin
        if (sub_i)
            lo_ext = {1'b0, a_i[HALF_W-1:0]} - {1'b0, b_i[HALF_W-1:0]} - {{HALF_W{1'b0}}, cin_i};
        else
            lo_ext = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin_i};
    end

    // Full-width operation: its top bit is the carry or borrow.
    always_comb begin
        if (sub_i)
            full_ext = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
        else
            full_ext = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
    end

    assign sum_o   = full_ext[DATA_W-1:0];
    assign half_o  = lo_ext[HALF_W];
    assign carry_o = full_ext[DATA_W];

endmodule

// File: rtl/alu8_logic.sv
// Module: bitwise AND / XOR / OR unit.
// Assumes the caller picks the result that matches the operation code.
module alu8_logic #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] xor_o,
    output logic [DATA_W-1:0] or_o
);
    // Three parallel bitwise results.
    always_comb begin
        and_o = a_i & b_i;
        xor_o = a_i ^ b_i;
        or_o  = a_i | b_i;
    end

endmodule

// File: rtl/alu8_step.sv
// Module: single-operand increment/decrement with a nibble-boundary flag.
// Assumes DATA_W is even. half_o marks a low nibble that wrapped:
// all zeros after an increment, all ones after a decrement.
module alu8_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val_i,
    input  logic              down_i,
    output logic [DATA_W-1:0] res_o,
    output logic              half_o
);
    localparam int HALF_W = DATA_W / 2;

    // Step by one in the chosen direction.
    always_comb begin
        if (down_i)
            res_o = val_i - {{(DATA_W-1){1'b0}}, 1'b1};
        else
            res_o = val_i + {{(DATA_W-1){1'b0}}, 1'b1};
    end

    // Nibble wrap detection on the stepped value.
    always_comb begin
        if (down_i)
            half_o = &res_o[HALF_W-1:0];
        else
            half_o = ~|res_o[HALF_W-1:0];
    end

endmodule

// File: rtl/alu8_flagged.sv
// Module: top of the flag-generating ALU. Selects between the two-operand
// operations and the step path, builds the flag byte, and registers all
// outputs on the rising clock edge.
// Assumes a synchronous active-low reset. Compare drops the writeback strobe
// but still presents the difference on res_out.
module alu8_flagged
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              step_en,
    input  logic              step_down,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opd_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res_out,
    output logic [7:0]        flags_out,
    output logic              wr_en_out
);
    alu_op_e op;
    logic    is_sub;
    logic    use_cin;

    logic [DATA_W-1:0] as_sum;
    logic              as_half;
    logic              as_carry;
    logic [DATA_W-1:0] lg_and, lg_xor, lg_or;
    logic [DATA_W-1:0] st_res;
    logic              st_half;

    logic [DATA_W-1:0] res_d;
    logic              n_d, h_d, c_d, wr_d;
    logic [7:0]        flags_d;

    // Decode the operation into subtract and carry-use controls.
    always_comb begin
        op      = alu_op_e'(op_sel);
        is_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        use_cin = (op == OP_ADC) || (op == OP_SBC);
    end

    alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i     (acc_in),
        .b_i     (opd_in),
        .sub_i   (is_sub),
        .cin_i   (use_cin & carry_in),
        .sum_o   (as_sum),
        .half_o  (as_half),
        .carry_o (as_carry)
    );

    alu8_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i   (acc_in),
        .b_i   (opd_in),
        .and_o (lg_and),
        .xor_o (lg_xor),
        .or_o  (lg_or)
    );

    alu8_step #(.DATA_W(DATA_W)) u_step (
        .val_i  (opd_in),
        .down_i (step_down),
        .res_o  (st_res),
        .half_o (st_half)
    );

    // Choose the result, N/H/C flags and writeback strobe for this cycle.
    always_comb begin
        res_d = as_sum;
        n_d   = 1'b0;
        h_d   = 1'b0;
        c_d   = 1'b0;
        wr_d  = 1'b1;
        if (step_en) begin
            res_d = st_res;
            n_d   = step_down;
            h_d   = st_half;
            c_d   = carry_in;
        end else begin
            unique case (op)
                OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
                    res_d = as_sum;
                    n_d   = is_sub;
                    h_d   = as_half;
                    c_d   = as_carry;
                    wr_d  = (op != OP_CMP);
                end
                OP_AND: begin
                    res_d = lg_and;
                    h_d   = 1'b1;
                end
                OP_XOR:  res_d = lg_xor;
                OP_OR:   res_d = lg_or;
                default: res_d = as_sum;
            endcase
        end
    end

    // Assemble the flag byte; zero comes from the truncated result.
    always_comb begin
        flags_d         = 8'h00;
        flags_d[FLAG_Z] = (res_d == '0);
        flags_d[FLAG_N] = n_d;
        flags_d[FLAG_H] = h_d;
        flags_d[FLAG_C] = c_d;
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= 8'h00;
            wr_en_out <= 1'b0;
        end else begin
            res_out   <= res_d;
            flags_out <= flags_d;
            wr_en_out <= wr_d;
        end
    end

    // Reset clears every output one edge later (R12).
    assert_reset_clear_R12: assert property (@(posedge clk)
        !rst_n |=> (res_out == '0 && flags_out == 8'h00 && !wr_en_out));

    // Compare never requests writeback (R5).
    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en) && $past(op_sel) == OP_CMP) |-> !wr_en_out);

    // Every other operation does request writeback (R11).
    assert_write_other_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(step_en) || $past(op_sel) != OP_CMP)) |-> wr_en_out);

    // Flag low nibble stays zero (R11).
    assert_low_nibble_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[3:0] == 4'h0);

    // Zero flag agrees with the registered result (R8).
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flags_out[FLAG_Z] == (res_out == '0)));

    // Step path passes the incoming carry through (R9, R10).
    assert_step_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(step_en)) |-> (flags_out[FLAG_C] == $past(carry_in)));

    // Logic operations clear subtract and carry (R6, R7).
    assert_logic_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en) && $past(op_sel[2]) && $past(op_sel) != OP_CMP)
        |-> (!flags_out[FLAG_N] && !flags_out[FLAG_C]));

    // Subtract-family operations set the subtract flag (R3).
    assert_sub_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(step_en) &&
         ($past(op_sel) == OP_SUB || $past(op_sel) == OP_SBC || $past(op_sel) == OP_CMP))
        |-> flags_out[FLAG_N]);

endmodule

// File: tb/alu8_flagged_tb.sv
// Bench: random and directed vectors checked against a reference function.
module alu8_flagged_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] op_sel;
    logic       step_en, step_down;
    logic [7:0] acc_in, opd_in;
    logic       carry_in;
    logic [7:0] res_out, flags_out;
    logic       wr_en_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alu8_flagged dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_sel    (op_sel),
        .step_en   (step_en),
        .step_down (step_down),
        .acc_in    (acc_in),
        .opd_in    (opd_in),
        .carry_in  (carry_in),
        .res_out   (res_out),
        .flags_out (flags_out),
        .wr_en_out (wr_en_out)
    );

    // Reference model: returns {wr, flags[7:0], result[7:0]}.
    function automatic logic [16:0] ref_model(input int op, input bit st, input bit dn,
                                              input int a, input int b, input int ci);
        int r; bit n, h, c, w;
        n = 0; h = 0; c = 0; w = 1;
        if (st) begin
            r = dn ? b - 1 : b + 1;
            n = dn;
            h = dn ? ((r & 15) == 15) : ((r & 15) == 0);
            c = ci[0];
        end else begin
            case (op)
                0, 1: begin
                    int k = (op == 1) ? ci : 0;
                    r = a + b + k;
                    h = ((a & 15) + (b & 15) + k) > 15;
                    c = r > 255;
                end
                2, 3, 7: begin
                    int k = (op == 3) ? ci : 0;
                    r = a - b - k;
                    n = 1;
                    h = ((b & 15) + k) > (a & 15);
                    c = (b + k) > a;
                    w = (op != 7);
                end
                4: begin r = a & b; h = 1; end
                5: r = a ^ b;
                default: r = a | b;
            endcase
        end
        r = r & 255;
        return {w, (r == 0), n, h, c, 4'h0, r[7:0]};
    endfunction

    function automatic string tag_of(input int op, input bit st, input bit dn);
        if (st) return dn ? "R10" : "R9";
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            5, 6: return "R7";
            default: return "R5";
        endcase
    endfunction

    // Apply one vector, wait one edge, compare result+flags and strobe.
    task automatic run_vec(input int op, input bit st, input bit dn,
                           input int a, input int b, input int ci);
        logic [16:0] e;
        e = ref_model(op, st, dn, a, b, ci);
        op_sel = op[2:0]; step_en = st; step_down = dn;
        acc_in = a[7:0]; opd_in = b[7:0]; carry_in = ci[0];
        @(posedge clk); #1;
        checks++;
        if ({flags_out, res_out} !== e[15:0]) begin
            errors++;
            $display("FAIL %s/R8 op=%0d st=%0d dn=%0d a=%02h b=%02h ci=%0d actual flags=%02h res=%02h expected flags=%02h res=%02h",
                     tag_of(op, st, dn), op, st, dn, a, b, ci, flags_out, res_out, e[15:8], e[7:0]);
        end
        checks++;
        if (wr_en_out !== e[16]) begin
            errors++;
            $display("FAIL %s op=%0d st=%0d actual wr=%0b expected wr=%0b",
                     (op == 7 && !st) ? "R5" : "R11", op, st, wr_en_out, e[16]);
        end
    endtask

    task automatic check_reset(input string when);
        checks++;
        if (res_out !== 8'h00 || flags_out !== 8'h00 || wr_en_out !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset %s actual res=%02h flags=%02h wr=%0b expected 00 00 0",
                     when, res_out, flags_out, wr_en_out);
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL R12 watchdog actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0; op_sel = 3'd0; step_en = 0; step_down = 0;
        acc_in = 8'h01; opd_in = 8'h01; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_reset("initial");  // R12
        rst_n = 1'b1;

        // Directed corners: nibble and byte boundaries.
        run_vec(0, 0, 0, 8'h0F, 8'h01, 0);  // R1 half carry
        run_vec(0, 0, 0, 8'hFF, 8'h01, 1);  // R1 zero+half+carry, carry_in ignored
        run_vec(1, 0, 0, 8'h0F, 8'h00, 1);  // R2 carry_in makes half
        run_vec(1, 0, 0, 8'hFF, 8'h00, 1);  // R2 carry_in wraps to zero
        run_vec(2, 0, 0, 8'h10, 8'h01, 0);  // R3 nibble borrow
        run_vec(2, 0, 0, 8'h05, 8'h05, 1);  // R3 zero, carry_in ignored
        run_vec(3, 0, 0, 8'h00, 8'h00, 1);  // R4 borrow only from carry_in
        run_vec(3, 0, 0, 8'h35, 8'h35, 1);  // R4 equal nibbles plus borrow
        run_vec(3, 0, 0, 8'h36, 8'h35, 1);  // R4 exact zero
        run_vec(7, 0, 0, 8'h42, 8'h42, 0);  // R5 equal compare, no write
        run_vec(7, 0, 0, 8'h01, 8'h02, 0);  // R5 less-than compare
        run_vec(4, 0, 0, 8'hF0, 8'h0F, 1);  // R6 zero with H set
        run_vec(5, 0, 0, 8'hAA, 8'hAA, 1);  // R7 xor to zero
        run_vec(6, 0, 0, 8'h00, 8'h00, 1);  // R7 or to zero
        run_vec(3, 1, 0, 8'h00, 8'hFF, 1);  // R9 wrap, op_sel/acc ignored
        run_vec(0, 1, 0, 8'h12, 8'h0F, 0);  // R9 nibble wrap
        run_vec(2, 1, 1, 8'hFF, 8'h10, 1);  // R10 nibble borrow
        run_vec(7, 1, 1, 8'h00, 8'h01, 0);  // R10 to zero, compare code ignored
        run_vec(5, 1, 1, 8'h77, 8'h00, 1);  // R10 wrap to FF

        // Exhaustive step path: both directions and both carries (R9, R10).
        for (int v = 0; v < 256; v++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 2; c++)
                    run_vec(int'($urandom_range(0, 7)), 1'b1, d[0], int'($urandom_range(0, 255)), v, c);

        // Random two-operand traffic over all codes and carries (R1-R8 family).
        for (int i = 0; i < 20000; i++)
            run_vec(int'($urandom_range(0, 7)), 1'b0, 1'b0,
                    int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 1)));

        // Mid-run reset overrides a live add (R12).
        op_sel = 3'd0; step_en = 0; acc_in = 8'h01; opd_in = 8'h01;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check_reset("mid-run");
        rst_n = 1'b1;
        run_vec(0, 0, 0, 8'h01, 8'h01, 0);  // R12 resumes after reset

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule